// File: doc/BRIEF.md
# Multidrop Address Character Recognizer

This block sits on the receive side of a serial channel, between the character deserializer and the receive FIFO. Each received character arrives with a flag that marks it as an address or a data character. The block compares characters against a programmed station address. From that comparison it decides whether the receiver accepts the data that follows. It also decides whether the current character is written into the FIFO, and it records match and mismatch events in a small status register that clears when read.

A two-bit mode field turns on two actions. The wake action makes a matching address turn the receiver on. The doze action makes a non-matching address turn it off. Either action can be used alone, both can be used together, or both can be left off. When the channel is not in multidrop mode, the same comparator works as a general character detector: every character is compared, whatever its flag. A keep bit decides whether recognized characters are written to the FIFO or stripped. An interrupt request is raised while a status event is pending and the interrupt mask allows it.

Top module: `mdrop_addr_rec`

## Requirements
- R1: After reset, `rx_enable` is 0 while `wake_mode_en`=1 and `mode_sel`≠0. After reset, `stat_bits` is 0 and `irq` is 0.
- R2: With `mode_sel`=00, every valid character asserts `fifo_wr` in its own cycle, no status bit is set, and `rx_enable` reads 1.
- R3: In multidrop mode with `mode_sel` bit 0 set, an address character equal to `station_addr` makes `rx_enable` 1 from the next cycle. After that, data characters assert `fifo_wr`.
- R4: In multidrop mode with `mode_sel` bit 1 set, an address character different from `station_addr` makes `rx_enable` 0 from the next cycle.
- R5: In multidrop mode with `mode_sel`≠0 and `rx_enable`=0, a data character never asserts `fifo_wr`. Address characters are still compared while the receiver is off.
- R6: With `mode_sel`=01, a non-matching address leaves `rx_enable` unchanged. With `mode_sel`=10, a matching address leaves `rx_enable` unchanged.
- R7: In multidrop mode with `mode_sel`≠0, an address character asserts `fifo_wr` exactly when `keep_addr`=1, whatever the state of `rx_enable`.
- R8: With `wake_mode_en`=0 and `mode_sel`≠0, every character is compared regardless of `char_is_addr`. A match sets `stat_bits[0]` and is written only when `keep_addr`=1. A non-matching character is always written. `rx_enable` stays 1 and `stat_bits[1]` is never set.
- R9: `stat_bits[0]` (match) and `stat_bits[1]` (multidrop address mismatch) are sticky from the cycle after their event. A `stat_rd` pulse clears them in the next cycle, except for a bit whose event arrives in the same cycle as the read, which stays set.
- R10: `irq` is 1 exactly when `irq_mask`=1 and at least one bit of `stat_bits` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | A received character is present this cycle |
| char_data | input | DATA_W | Received character |
| char_is_addr | input | 1 | Character is flagged as an address character |
| station_addr | input | DATA_W | Programmed station address / match value |
| mode_sel | input | 2 | 00 off, 01 wake, 10 doze, 11 wake and doze |
| wake_mode_en | input | 1 | Channel is in multidrop mode; 0 selects detector use |
| keep_addr | input | 1 | Write recognized characters to the FIFO |
| irq_mask | input | 1 | Interrupt enable for recognition events |
| stat_rd | input | 1 | Status register read strobe (clears on read) |
| rx_enable | output | 1 | Receiver accepts data characters |
| fifo_wr | output | 1 | Write qualifier for the current character |
| stat_bits | output | 2 | bit0 match seen, bit1 address mismatch seen |
| irq | output | 1 | Recognition interrupt request |

## Verification
Directed sequences walk through each mode with three kinds of character: matching addresses, non-matching addresses, and data. This separates the wake action from the doze action, and it shows whether each one acts alone when the other bit is clear. Data sent while the receiver is off, followed by a matching address, shows that comparison continues during doze. In detector mode, a matching character sent with its address flag clear shows that the flag is ignored there. Reads issued in the same cycle as a new event show whether the set takes priority over the clear. A seeded random run then mixes modes, keep settings, flags, reads and characters, about half of them equal to the station address, against a bench reference model.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  typedef enum logic [1:0] {
    RM_OFF  = 2'b00,
    RM_WAKE = 2'b01,
    RM_DOZE = 2'b10,
    RM_BOTH = 2'b11
  } rec_mode_e;

  typedef struct packed {
    logic recog;
    logic hit;
    logic miss;
    logic wake_req;
    logic doze_req;
  } rec_ev_t;

  function automatic logic mode_active(rec_mode_e m);
    return m != RM_OFF;
  endfunction

  function automatic logic mode_wakes(rec_mode_e m);
    return (m == RM_WAKE) || (m == RM_BOTH);
  endfunction

  function automatic logic mode_dozes(rec_mode_e m);
    return (m == RM_DOZE) || (m == RM_BOTH);
  endfunction

endpackage

// File: rtl/mdr_classify.sv
module mdr_classify
  import mdr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_is_addr,
  input  logic [DATA_W-1:0] station_addr,
  input  rec_mode_e         mode,
  input  logic              wake_mode_en,
  output rec_ev_t           ev
);

  function automatic logic chars_equal(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  logic active;
  logic eq;

  always_comb begin
    active = char_valid && mode_active(mode);
    eq     = chars_equal(char_data, station_addr);
    ev     = '0;
    if (wake_mode_en) begin
      ev.recog = active && char_is_addr;
      ev.hit   = ev.recog && eq;
      ev.miss  = ev.recog && !eq;
    end else begin
      ev.recog = active && eq;
      ev.hit   = ev.recog;
      ev.miss  = 1'b0;
    end
    ev.wake_req = wake_mode_en && ev.hit && mode_wakes(mode);
    ev.doze_req = ev.miss && mode_dozes(mode);
  end

endmodule

// File: rtl/mdr_gate.sv
module mdr_gate
  import mdr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      char_valid,
  input  logic      char_is_addr,
  input  logic      wake_mode_en,
  input  rec_mode_e mode,
  input  logic      keep_addr,
  input  logic      recog,
  input  logic      wake_req,
  input  logic      doze_req,
  output logic      rx_state,
  output logic      rx_enable,
  output logic      fifo_wr
);

  logic gating_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_state <= 1'b0;
    end else if (wake_req) begin
      rx_state <= 1'b1;
    end else if (doze_req) begin
      rx_state <= 1'b0;
    end
  end

  always_comb begin
    gating_on = wake_mode_en && mode_active(mode);
    rx_enable = gating_on ? rx_state : 1'b1;
    if (!char_valid) begin
      fifo_wr = 1'b0;
    end else if (recog) begin
      fifo_wr = keep_addr;
    end else if (gating_on && !char_is_addr) begin
      fifo_wr = rx_state;
    end else begin
      fifo_wr = 1'b1;
    end
  end

endmodule

// File: rtl/mdr_status.sv
module mdr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_ev,
  input  logic       miss_ev,
  input  logic       stat_rd,
  input  logic       irq_mask,
  output logic [1:0] stat_bits,
  output logic       irq
);

  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set || (cur && !clr);
  endfunction

  logic hit_q, miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      hit_q  <= sticky_next(hit_q, hit_ev, stat_rd);
      miss_q <= sticky_next(miss_q, miss_ev, stat_rd);
    end
  end

  assign stat_bits = {miss_q, hit_q};
  assign irq       = irq_mask && (hit_q || miss_q);

endmodule

// File: rtl/mdrop_addr_rec.sv
module mdrop_addr_rec
  import mdr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_is_addr,
  input  logic [DATA_W-1:0] station_addr,
  input  logic [1:0]        mode_sel,
  input  logic              wake_mode_en,
  input  logic              keep_addr,
  input  logic              irq_mask,
  input  logic              stat_rd,
  output logic              rx_enable,
  output logic              fifo_wr,
  output logic [1:0]        stat_bits,
  output logic              irq
);

  rec_mode_e mode;
  rec_ev_t   ev;
  logic      hit_ev;
  logic      miss_ev;
  logic      rx_state;

  assign mode    = rec_mode_e'(mode_sel);
  assign hit_ev  = ev.hit;
  assign miss_ev = ev.miss;

  mdr_classify #(.DATA_W(DATA_W)) u_cls (
    .char_valid   (char_valid),
    .char_data    (char_data),
    .char_is_addr (char_is_addr),
    .station_addr (station_addr),
    .mode         (mode),
    .wake_mode_en (wake_mode_en),
    .ev           (ev)
  );

  mdr_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .char_valid   (char_valid),
    .char_is_addr (char_is_addr),
    .wake_mode_en (wake_mode_en),
    .mode         (mode),
    .keep_addr    (keep_addr),
    .recog        (ev.recog),
    .wake_req     (ev.wake_req),
    .doze_req     (ev.doze_req),
    .rx_state     (rx_state),
    .rx_enable    (rx_enable),
    .fifo_wr      (fifo_wr)
  );

  mdr_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ev    (hit_ev),
    .miss_ev   (miss_ev),
    .stat_rd   (stat_rd),
    .irq_mask  (irq_mask),
    .stat_bits (stat_bits),
    .irq       (irq)
  );

endmodule

// File: rtl/mdr_checker.sv
module mdr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       char_valid,
  input logic       char_is_addr,
  input logic [1:0] mode_sel,
  input logic       wake_mode_en,
  input logic       keep_addr,
  input logic       irq_mask,
  input logic       stat_rd,
  input logic       rx_enable,
  input logic       fifo_wr,
  input logic [1:0] stat_bits,
  input logic       irq,
  input logic       hit_ev,
  input logic       miss_ev,
  input logic       rx_state
);

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && mode_sel == 2'b00) |-> (fifo_wr && !hit_ev && !miss_ev));

  assert_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev && wake_mode_en && mode_sel[0]) |=> rx_state);

  assert_doze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ev && mode_sel[1]) |=> !rx_state);

  assert_doze_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_is_addr && wake_mode_en && mode_sel != 2'b00 && !rx_enable)
      |-> !fifo_wr);

  assert_strip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_is_addr && wake_mode_en && mode_sel != 2'b00)
      |-> (fifo_wr == keep_addr));

  assert_no_miss_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_mode_en |-> (!miss_ev && rx_enable));

  assert_hit_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> stat_bits[0]);

  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !hit_ev && !miss_ev) |=> (stat_bits == 2'b00));

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_mask);

endmodule

bind mdrop_addr_rec mdr_checker u_chk (.*);

// File: tb/mdrop_addr_rec_tb.sv
`timescale 1ns/1ps
module mdrop_addr_rec_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_is_addr = 1'b0;
  logic [7:0] station_addr = 8'h5A;
  logic [1:0] mode_sel = 2'b11;
  logic       wake_mode_en = 1'b1;
  logic       keep_addr = 1'b0;
  logic       irq_mask = 1'b0;
  logic       stat_rd = 1'b0;
  logic       rx_enable, fifo_wr, irq;
  logic [1:0] stat_bits;

  int n_chk = 0;
  int n_fail = 0;

  logic m_rx = 1'b0, m_hit = 1'b0, m_miss = 1'b0;

  always #4 clk = ~clk;

  mdrop_addr_rec #(.DATA_W(8)) u_dut (.*);

  function automatic logic f_wr(logic [7:0] d, logic a);
    if (mode_sel == 2'b00) return 1'b1;
    if (wake_mode_en) return a ? keep_addr : m_rx;
    return (d == station_addr) ? keep_addr : 1'b1;
  endfunction

  function automatic logic f_rxen();
    return (wake_mode_en && mode_sel != 2'b00) ? m_rx : 1'b1;
  endfunction

  function automatic string f_wr_tag(logic a);
    if (mode_sel == 2'b00) return "R2";
    if (!wake_mode_en) return "R8";
    return a ? "R7" : "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle; call at a negedge
  task automatic step(logic v, logic [7:0] d, logic a, logic rd);
    logic hev, mev, eq;
    char_valid = v; char_data = d; char_is_addr = a; stat_rd = rd;
    #1;
    if (v) chk(f_wr_tag(a), fifo_wr, f_wr(d, a));
    eq  = (d == station_addr);
    hev = 1'b0; mev = 1'b0;
    if (v && mode_sel != 2'b00) begin
      if (wake_mode_en) begin
        hev = a && eq;
        mev = a && !eq;
      end else begin
        hev = eq;
      end
    end
    @(posedge clk);
    if (wake_mode_en && hev && mode_sel[0]) m_rx = 1'b1;
    else if (mev && mode_sel[1]) m_rx = 1'b0;
    m_hit  = hev || (m_hit && !rd);
    m_miss = mev || (m_miss && !rd);
    @(negedge clk);
    char_valid = 1'b0; stat_rd = 1'b0;
    #1;
    chk(wake_mode_en ? "R4" : "R8", rx_enable, f_rxen());
    chk("R9", stat_bits, {m_miss, m_hit});
    chk("R10", irq, irq_mask && (m_hit || m_miss));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", rx_enable, 0);
    chk("R1", stat_bits, 0);
    chk("R1", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: data dropped while off
    step(1, 8'h11, 0, 0);
    // R3 with R7 stripping
    step(1, 8'h5A, 1, 0);
    chk("R3", rx_enable, 1);
    step(1, 8'h22, 0, 0);
    // R4: mismatch dozes
    step(1, 8'h33, 1, 0);
    chk("R4", rx_enable, 0);
    step(1, 8'h44, 0, 0);
    // R9: read clears
    step(0, 8'h00, 0, 1);
    chk("R9", stat_bits, 0);
    // R5: compare continues while off; R9 set beats read
    step(1, 8'h5A, 1, 1);
    chk("R9", stat_bits, 1);
    chk("R5", rx_enable, 1);
    // R6: wake-only ignores mismatch
    mode_sel = 2'b01;
    step(1, 8'h77, 1, 0);
    chk("R6", rx_enable, 1);
    // R6: doze-only ignores match
    mode_sel = 2'b10;
    step(1, 8'h01, 1, 0);
    step(1, 8'h5A, 1, 0);
    chk("R6", rx_enable, 0);
    // R7: keep writes address chars even while off
    keep_addr = 1'b1;
    step(1, 8'h5A, 1, 0);
    step(1, 8'h09, 1, 0);
    // R10
    irq_mask = 1'b1;
    #1 chk("R10", irq, 1);
    step(0, 8'h00, 0, 1);
    // R8 detector: flag ignored
    wake_mode_en = 1'b0; mode_sel = 2'b01; keep_addr = 1'b0;
    step(1, 8'h5A, 0, 0);
    step(1, 8'h12, 1, 0);
    keep_addr = 1'b1;
    step(1, 8'h5A, 1, 1);
    // R2 mode off
    mode_sel = 2'b00; wake_mode_en = 1'b1; keep_addr = 1'b0;
    step(1, 8'h5A, 1, 1);
    step(1, 8'h66, 1, 0);
    step(1, 8'h67, 0, 0);
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 16) == 0) begin
        mode_sel     = 2'($urandom);
        wake_mode_en = ($urandom % 4) != 0;
        keep_addr    = 1'($urandom);
        irq_mask     = 1'($urandom);
      end
      step(($urandom % 4) != 0,
           ($urandom % 2) ? station_addr : 8'($urandom),
           1'($urandom),
           ($urandom % 5) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule